// File: doc/BRIEF.md
# Byte-Lane Masked Word Data Memory

This block is the data store of a 32-bit processor that uses byte addresses. It holds a parameterised number of 32-bit words behind one port. A request strobe qualifies every access, and a write-enable input chooses between a read and a write. On a write, a 4-bit lane mask selects which of the four bytes of the addressed word take the new data. On a read, the whole addressed word is captured in an output register and shows up one clock edge later.

The word index comes from the byte address with the two lane-select bits dropped. Only as many bits as the word count needs are used, so higher address bits alias. A later load/store stage picks out bytes and halfwords from the returned word and sign-extends them. The output register is cleared by a synchronous active-low reset, while the stored words are left as they are. A ready output stays high because every read completes in a single cycle.

Top module: `dmem_word_store`

## Requirements
- R1: `mem_ready` is 1 in every cycle.
- R2: A clock edge with `rst_n` low sets `rd_data` to 0.
- R3: A read request (`mem_req`=1, `wr_en`=0) at an edge loads `rd_data` with the word at index `addr[2 +: log2(WORDS)]` at that same edge, giving a latency of one cycle.
- R4: An edge with `mem_req`=0 leaves `rd_data` unchanged.
- R5: A write request (`mem_req`=1, `wr_en`=1) leaves `rd_data` unchanged.
- R6: In a write request, each bit i of `byte_en` that is 1 replaces bits [8i+7:8i] of the addressed word with the same bits of `wr_data`. For example, a write to byte address 0x6 with mask 0100 and data 0x00A50000 sets byte lane 2 of word 1 to 0xA5.
- R7: Bytes whose `byte_en` bit is 0 keep their contents. A write with mask 0000 changes nothing.
- R8: With `mem_req`=0, `wr_en`=1 changes no stored word.
- R9: Address bits [1:0] and all bits above the index field are ignored, so those addresses alias onto the same word.
- R10: A read issued on the cycle right after a write to the same word returns the updated word.
- R11: Reset leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read register |
| mem_req | input | 1 | Access request strobe |
| wr_en | input | 1 | 1 = write request, 0 = read request |
| byte_en | input | 4 | Per-lane write mask, bit i covers bits [8i+7:8i] |
| addr | input | 32 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read word |
| mem_ready | output | 1 | Constant 1 |

## Verification
The bench runs a 16-word configuration. It sweeps all sixteen lane masks over one word and reads the word back on the very next cycle. A design that decodes the mask wrongly, ignores it, or reads through a stale path would return bytes that do not match the arithmetic model. The bench also sets high address bits and low lane bits and reads through the plain index, so a design that decodes too many or too few bits would miss the word. It drives idle cycles, write cycles and request-less writes between reads, so an output register that reloads without a read request, or a store that accepts a write without a request, shows up as a changed word. A reset in the middle of the run, followed by reads, catches a design that clears the store or fails to clear the output.

// File: rtl/dmem_pkg.sv
// Shared sizes and types for the byte-lane data memory.
// Assumes the data word is a whole number of 8-bit lanes.
package dmem_pkg;
    localparam int DATA_W     = 32;
    localparam int LANE_W     = 8;
    localparam int LANES      = DATA_W / LANE_W;
    localparam int LANE_SEL_W = $clog2(LANES);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANES-1:0]  mask_t;
endpackage

// File: rtl/dmem_addr_split.sv
// Turns a byte address into a word index.
// Assumes WORDS is a power of two and that the index field fits inside the address.
// The lane-select bits and every bit above the index field are dropped.
module dmem_addr_split
    import dmem_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    generate
        if ((1 << IDX_W) != WORDS) begin : g_bad_words
            $error("WORDS must be a power of two");
        end
        if (IDX_W + LANE_SEL_W >= ADDR_W) begin : g_bad_addr
            $error("index field does not fit in the address");
        end
    endgenerate

    // Pick the index field that sits just above the lane-select bits.
    assign idx = addr[LANE_SEL_W +: IDX_W];

    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:LANE_SEL_W+IDX_W], addr[LANE_SEL_W-1:0]};
endmodule

// File: rtl/dmem_ctrl.sv
// Decodes the request, write-enable and lane mask into per-lane write
// strobes and a load strobe for the read register.
// Assumes the inputs are stable around the rising clock edge.
module dmem_ctrl
    import dmem_pkg::*;
(
    input  logic  mem_req,
    input  logic  wr_en,
    input  mask_t byte_en,
    output mask_t lane_wr,
    output logic  rd_load
);
    logic wr_req;

    // A write needs both the request and the write-enable.
    assign wr_req = mem_req & wr_en;

    // One write strobe per lane, gated by its own mask bit.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane_strobe
            assign lane_wr[g] = wr_req & byte_en[g];
        end
    endgenerate

    // Only a read request loads the output register.
    assign rd_load = mem_req & ~wr_en;
endmodule

// File: rtl/dmem_lane_bank.sv
// Storage for one byte lane of every word: a synchronous write and a
// combinational read at the same index. Contents are never reset.
// Assumes idx stays below WORDS, which holds because the index is log2(WORDS) bits wide.
module dmem_lane_bank #(
    parameter int WORDS  = 256,
    parameter int LANE_W = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] wbyte,
    output logic [LANE_W-1:0] rbyte
);
    logic [LANE_W-1:0] cells [WORDS];

    // Store the byte when this lane is strobed.
    always_ff @(posedge clk) begin
        if (wr) cells[idx] <= wbyte;
    end

    // Present the addressed byte for the read register.
    assign rbyte = cells[idx];

    AST_LANE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cells[$past(idx)] == $past(wbyte)) else $error("lane write lost"); // R6
endmodule

// File: rtl/dmem_read_reg.sv
// Output register of the read port: loads on request, otherwise holds.
// Cleared by a synchronous active-low reset.
module dmem_read_reg
    import dmem_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t d,
    output word_t q
);
    // Capture the word on a read request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/dmem_word_store.sv
// Word-organised data memory with per-byte write mask and a one-cycle
// registered read. Assumes WORDS is a power of two; high address bits alias.
module dmem_word_store
    import dmem_pkg::*;
#(
    parameter int WORDS  = 256,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              wr_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ready
);
    logic [IDX_W-1:0] idx;
    mask_t            lane_wr;
    logic             rd_load;
    word_t            word_rd;

    dmem_addr_split #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_split (
        .addr (addr),
        .idx  (idx)
    );

    dmem_ctrl u_ctrl (
        .mem_req (mem_req),
        .wr_en   (wr_en),
        .byte_en (byte_en),
        .lane_wr (lane_wr),
        .rd_load (rd_load)
    );

    // One storage bank per byte lane.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_bank
            dmem_lane_bank #(.WORDS(WORDS), .LANE_W(LANE_W)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .wr    (lane_wr[g]),
                .idx   (idx),
                .wbyte (wr_data[g*LANE_W +: LANE_W]),
                .rbyte (word_rd[g*LANE_W +: LANE_W])
            );
        end
    endgenerate

    dmem_read_reg u_rreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .d     (word_rd),
        .q     (rd_data)
    );

    // Single-cycle access, so always ready.
    assign mem_ready = 1'b1;

    AST_READY_HIGH: assert property (@(posedge clk)
        mem_ready == 1'b1) else $error("ready dropped"); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0) else $error("reset did not clear"); // R2
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !wr_en) |=> rd_data == $past(word_rd)) else $error("read latency"); // R3
    AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> $stable(rd_data)) else $error("idle reload"); // R4
    AST_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && wr_en) |=> $stable(rd_data)) else $error("write reload"); // R5
endmodule

// File: tb/sim_dmem_word_store.sv
`timescale 1ns/1ps
module sim_dmem_word_store;
    localparam int WORDS = 16;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  byte_en = 4'h0;
    logic [31:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        mem_ready;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [WORDS];
    logic [31:0] exp_rd = '0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    dmem_word_store #(.WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .wr_en(wr_en),
        .byte_en(byte_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, update the model, then check after the edge.
    task automatic op(input logic rq, input logic we, input logic [3:0] m,
                      input logic [31:0] a, input logic [31:0] d, input string req);
        logic [IW-1:0] i = a[2 +: IW];
        mem_req = rq; wr_en = we; byte_en = m; addr = a; wr_data = d;
        if (rq && !we) exp_rd = model[i];
        if (rq && we) model[i] = merge(model[i], d, m);
        @(negedge clk);
        check(req, rd_data, exp_rd);
        check("R1", {31'd0, mem_ready}, 32'd1);
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = 'x;
        @(negedge clk); @(negedge clk);
        check("R2", rd_data, 32'd0);
        check("R1", {31'd0, mem_ready}, 32'd1);
        rst_n = 1'b1;
        // R6: fill every word fully, then read each back
        for (int i = 0; i < WORDS; i++)
            op(1, 1, 4'hF, i * 4, 32'h0101_0101 * (i + 1) ^ 32'hC35A_0000, "R5");
        for (int i = 0; i < WORDS; i++) op(1, 0, 4'h0, i * 4, 0, "R3");
        // R6 R7 R10: all masks on word 3, read right after each write
        for (int m = 0; m < 16; m++) begin
            op(1, 1, 4'(m), 12, 32'h1111_1111 * m + 32'h0F0E_0D0C, "R6");
            op(1, 0, 4'h0, 12, 0, (m == 0) ? "R7" : "R10");
        end
        // R6: byte address 6, lane 2 of word 1
        op(1, 1, 4'b0100, 6, 32'h00A5_0000, "R5");
        op(1, 0, 4'h0, 4, 0, "R6");
        check("R6", {24'd0, rd_data[23:16]}, 32'hA5);
        // R8: request-less write
        op(0, 1, 4'hF, 20, 32'hDEAD_BEEF, "R4");
        op(1, 0, 4'h0, 20, 0, "R8");
        // R4 R5: holds across idle and writes to another word
        op(0, 0, 4'h0, 40, 0, "R4");
        op(0, 1, 4'hF, 44, 32'h5555_AAAA, "R4");
        op(1, 1, 4'b1001, 48, 32'h7700_0077, "R5");
        // R9: aliasing through high bits and lane bits
        op(1, 1, 4'hF, 32'hABC0_0000 | (7 * 4) | 3, 32'hFACE_0042, "R5");
        op(1, 0, 4'h0, 7 * 4, 0, "R9");
        op(1, 0, 4'h0, 32'h8000_0000 | (7 * 4) | 1, 0, "R9");
        // R2 R11: reset clears output, keeps contents
        rst_n = 1'b0; mem_req = 1'b0;
        @(negedge clk);
        check("R2", rd_data, 32'd0);
        exp_rd = '0;
        rst_n = 1'b1;
        op(1, 0, 4'h0, 7 * 4, 0, "R11");
        op(1, 0, 4'h0, 12, 0, "R11");
        // Randomised mixed traffic
        for (int n = 0; n < 400; n++) begin
            rng = next_rng(rng);
            op(rng[0] | rng[1], rng[2], rng[6:3], {rng[31:24], 18'd0, rng[11:8], rng[13:12]},
               next_rng(rng ^ 32'h9E37_79B9), "R3");
        end
        for (int i = 0; i < WORDS; i++) op(1, 0, 4'h0, i * 4, 0, "R6");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule